// File: doc/BRIEF.md
# Word-Serial Rate-Block Padder

This block gathers a byte message that arrives as a stream of 32-bit words and builds 576-bit rate blocks for a 512-bit-digest sponge hash. Each accepted word is shifted into a wide buffer from the low end. When eighteen words have been collected, the block goes to a permutation engine. The next block does not start filling until that engine acknowledges the current one. While a block waits, the input side is held off with a ready signal.

The end of the message is marked in one of two ways. A partial word carries a nonzero byte count, or the word strobe drops after a full word. At the end, the block pads the message with the hash's domain-separated pad rule: 0x06 goes in the first free byte and 0x80 in the top byte of the rate. When those two positions coincide they merge into 0x86. A message that fills its last block exactly gets one extra block that holds only padding. Only the final block carries the last-block flag.

The controller has four states. ST_IDLE waits for the first word of a message. ST_FILL accepts words. ST_PAD inserts padding words with no input. ST_OFFER presents a complete block. The transitions are:
- IDLE→FILL or FILL→FILL on a full word that leaves the block short.
- IDLE/FILL→PAD on a partial word that leaves the block short.
- FILL→PAD when the strobe drops.
- Any of IDLE, FILL or PAD→OFFER when the eighteenth word is shifted in.
- OFFER→FILL on acknowledge of a non-final block.
- OFFER→IDLE on acknowledge of the final block.

Top module: `sp_rate_padder`

## Requirements
- R1: After reset, in_ready is 1, blk_valid is 0 and blk_last is 0.
- R2: Byte i of a word sits in word_data[8i+7:8i]. Message byte k of a block appears at blk_data[8k+7:8k], where k counts from the block's first byte (k = 0..71).
- R3: blk_valid rises after exactly eighteen words have been shifted into the block. While blk_valid is high, in_ready is 0 and no word is taken.
- R4: blk_data and blk_last hold steady while blk_valid is high without blk_ack. The cycle after blk_ack, blk_valid is low.
- R5: When word_rdy is low in ST_FILL after a full word, the final block holds 0x06 at the first byte after the message, 0x80 at byte 71 and zeros in between.
- R6: word_cnt = 1, 2 or 3 marks a partial final word with that many valid bytes (0 means all four). Bytes of word_data above the count are ignored and replaced by padding.
- R7: A message whose last byte lands at byte 70 of a block gets 0x86 at byte 71.
- R8: A message of 72·n bytes produces one extra block: 0x06 at byte 0, 0x80 at byte 71, zeros elsewhere.
- R9: blk_last is 1 on the final padded block of a message and 0 on every earlier block.
- R10: In ST_IDLE, a low word_rdy or a stray blk_ack produces no block, and in_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_data | input | 32 | Message word, byte 0 in the low bits |
| word_rdy | input | 1 | Word strobe; low in ST_FILL ends the message |
| word_cnt | input | 2 | Valid bytes of a final partial word, 0 = full word |
| blk_ack | input | 1 | Permutation side has taken the block |
| blk_data | output | 576 | Assembled rate block, byte k at bits 8k+7:8k |
| blk_valid | output | 1 | Block is presented |
| blk_last | output | 1 | Presented block is the final padded block |
| in_ready | output | 1 | A word is accepted this cycle if word_rdy is high |

## Verification
Every message length from 1 to 150 bytes is driven. This covers each byte count of a partial last word at every word slot, and full-word endings at every slot. It also covers the 71-byte and 143-byte cases where the two pad bytes merge, and the 72-byte and 144-byte cases that need a padding-only block. Each position byte is checked, so a wrong byte order shows up separately from a wrong pad position or a pad merge error. Acknowledge delays vary from block to block so that the hold and release behaviour is exercised. Between messages the bench leaves the strobe low and sends stray acknowledges, to confirm that the idle state produces no block.

// File: rtl/sp_pad_pkg.sv
package sp_pad_pkg;
    localparam int WORD_W = 32;
    localparam int RATE_W = 576;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_PAD,
        ST_OFFER
    } pad_state_t;
endpackage

// File: rtl/sp_word_form.sv
// Builds the word shifted into the rate buffer: kept message bytes,
// an optional domain byte just past them, an optional closing bit.
module sp_word_form #(
    parameter int WORD_W = sp_pad_pkg::WORD_W,
    localparam int NB    = WORD_W / 8,
    localparam int KW    = $clog2(NB + 1)
) (
    input  logic [WORD_W-1:0] src,
    input  logic [KW-1:0]     keep,
    input  logic              put_dom,
    input  logic              put_end,
    output logic [WORD_W-1:0] word
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [7:0] b_msg, b_dom, b_end;
        assign b_msg = (KW'(i) < keep) ? src[8*i +: 8] : 8'h00;
        assign b_dom = (put_dom && KW'(i) == keep) ? 8'h06 : 8'h00;
        assign b_end = (put_end && i == NB - 1) ? 8'h80 : 8'h00;
        assign word[8*i +: 8] = b_msg | b_dom | b_end;
    end
endmodule

// File: rtl/sp_rate_shreg.sv
// Wide shift buffer: new word enters at the low end; the output reverses
// word order so that the first word lands at the lowest bits of the block.
module sp_rate_shreg #(
    parameter int WORD_W = sp_pad_pkg::WORD_W,
    parameter int RATE_W = sp_pad_pkg::RATE_W,
    localparam int NW    = RATE_W / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] word,
    output logic [RATE_W-1:0] blk
);
    logic [RATE_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[RATE_W-WORD_W-1:0], word};
    end

    for (genvar j = 0; j < NW; j++) begin : g_remap
        assign blk[WORD_W*j +: WORD_W] = sr_q[WORD_W*(NW-1-j) +: WORD_W];
    end
endmodule

// File: rtl/sp_rate_padder.sv
module sp_rate_padder #(
    parameter int WORD_W = sp_pad_pkg::WORD_W,
    parameter int RATE_W = sp_pad_pkg::RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_rdy,
    input  logic [1:0]        word_cnt,
    input  logic              blk_ack,
    output logic [RATE_W-1:0] blk_data,
    output logic              blk_valid,
    output logic              blk_last,
    output logic              in_ready
);
    import sp_pad_pkg::*;

    localparam int NW   = RATE_W / WORD_W;
    localparam int IW   = $clog2(NW);
    localparam int NB   = WORD_W / 8;
    localparam int KW   = $clog2(NB + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(NW - 1);

    pad_state_t st_q, st_d;
    logic [IW-1:0] widx_q;
    logic          dom_pend_q;
    logic          last_q;

    logic          accept, partial, shift_en, at_end;
    logic [KW-1:0] keep;
    logic          put_dom, put_end;
    logic [WORD_W-1:0] ins_word;

    assign at_end  = (widx_q == LAST_IDX);
    assign partial = (word_cnt != 2'd0);

    // output process
    always_comb begin
        in_ready  = 1'b0;
        blk_valid = 1'b0;
        blk_last  = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_FILL: in_ready = 1'b1;
            ST_PAD:           ;
            ST_OFFER: begin
                blk_valid = 1'b1;
                blk_last  = last_q;
            end
        endcase
    end

    assign accept   = in_ready && word_rdy;
    assign shift_en = accept || (st_q == ST_PAD);

    always_comb begin
        if (st_q == ST_PAD) begin
            keep    = '0;
            put_dom = dom_pend_q;
            put_end = at_end;
        end else begin
            keep    = partial ? KW'(word_cnt) : KW'(NB);
            put_dom = partial;
            put_end = partial && at_end;
        end
    end

    sp_word_form #(.WORD_W(WORD_W)) u_form (
        .src     (word_data),
        .keep    (keep),
        .put_dom (put_dom),
        .put_end (put_end),
        .word    (ins_word)
    );

    sp_rate_shreg #(.WORD_W(WORD_W), .RATE_W(RATE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .word     (ins_word),
        .blk      (blk_data)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_FILL: begin
                if (accept) begin
                    if (at_end)       st_d = ST_OFFER;
                    else if (partial) st_d = ST_PAD;
                    else              st_d = ST_FILL;
                end else if (st_q == ST_FILL) begin
                    st_d = ST_PAD;
                end
            end
            ST_PAD:   if (at_end)  st_d = ST_OFFER;
            ST_OFFER: if (blk_ack) st_d = last_q ? ST_IDLE : ST_FILL;
        endcase
    end

    // state register and its companions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            widx_q     <= '0;
            dom_pend_q <= 1'b0;
            last_q     <= 1'b0;
        end else begin
            st_q <= st_d;
            if (shift_en) widx_q <= at_end ? '0 : widx_q + 1'b1;
            if (st_q == ST_FILL && !word_rdy) dom_pend_q <= 1'b1;
            else if (shift_en)                dom_pend_q <= 1'b0;
            if (shift_en && at_end)
                last_q <= (st_q == ST_PAD) || partial;
        end
    end

    // R4: a presented block is frozen until taken
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid && !blk_ack |=> blk_valid && $stable(blk_data) && $stable(blk_last));
    // R4: acknowledge releases the block
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid && blk_ack |=> !blk_valid);
    // R5: every final block closes with the top pad bit
    a_r5_close_bit: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid && blk_last |-> blk_data[RATE_W-1]);
    // R3: no word is taken while a block waits
    a_r3_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> !in_ready);
    // R10: idle with no strobe creates no block
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_IDLE && !word_rdy |=> !blk_valid && in_ready);
endmodule

// File: tb/sp_rate_padder_bench.sv
module sp_rate_padder_bench;
    localparam int WORD_W = 32;
    localparam int RATE_W = 576;
    localparam int RB     = RATE_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] word_data = '0;
    logic              word_rdy = 1'b0;
    logic [1:0]        word_cnt = 2'd0;
    logic              blk_ack = 1'b0;
    logic [RATE_W-1:0] blk_data;
    logic              blk_valid, blk_last, in_ready;

    int n_vec  = 0;
    int n_bad  = 0;
    bit msg_done;

    always #2 clk = ~clk;

    sp_rate_padder u_sp_rate_padder (
        .clk(clk), .rst_n(rst_n), .word_data(word_data), .word_rdy(word_rdy),
        .word_cnt(word_cnt), .blk_ack(blk_ack), .blk_data(blk_data),
        .blk_valid(blk_valid), .blk_last(blk_last), .in_ready(in_ready)
    );

    function automatic logic [7:0] msg_byte(int len, int k);
        return 8'((k * 37 + len * 11 + 5) & 255);
    endfunction

    task automatic check(bit ok, string req, logic [RATE_W-1:0] act, logic [RATE_W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_word(logic [31:0] d, logic [1:0] c);
        @(negedge clk);
        word_rdy  = 1'b1;
        word_data = d;
        word_cnt  = c;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic drive_msg(int len);
        int nw;
        nw = (len + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] d;
            int rem;
            rem = len - 4 * w;
            for (int i = 0; i < 4; i++) begin
                int k;
                k = 4 * w + i;
                d[8*i +: 8] = (k < len) ? msg_byte(len, k) : (8'hA5 ^ 8'(k));
            end
            put_word(d, (rem >= 4) ? 2'd0 : 2'(rem));
        end
        @(negedge clk);
        word_rdy = 1'b0;
    endtask

    task automatic take_blocks(int len);
        int nb;
        nb = len / RB + 1;
        for (int b = 0; b < nb; b++) begin
            logic [RATE_W-1:0] exp;
            string tag;
            bit fin;
            fin = (b == nb - 1);
            for (int j = 0; j < RB; j++) begin
                int g;
                logic [7:0] v;
                g = RB * b + j;
                v = (g < len) ? msg_byte(len, g) : 8'h00;
                if (g == len) v = v | 8'h06;
                if (fin && j == RB - 1) v = v | 8'h80;
                exp[8*j +: 8] = v;
            end
            if (fin && len % RB == 0)        tag = "R8";
            else if (fin && len % RB == 71)  tag = "R7";
            else if (fin && len % 4 != 0)    tag = "R6";
            else if (fin)                    tag = "R5";
            else                             tag = "R2";
            @(negedge clk);
            while (!blk_valid) @(negedge clk);
            check(blk_data === exp, tag, blk_data, exp);
            check(blk_last === fin, "R9", RATE_W'(blk_last), RATE_W'(fin));
            check(in_ready === 1'b0, "R3", RATE_W'(in_ready), '0);
            if ((len + b) % 3 != 0) begin
                repeat ((len + b) % 3) @(negedge clk);
                check(blk_valid === 1'b1 && blk_data === exp, "R4", blk_data, exp);
            end
            blk_ack = 1'b1;
            @(negedge clk);
            blk_ack = 1'b0;
            check(blk_valid === 1'b0, "R4", RATE_W'(blk_valid), '0);
        end
        msg_done = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready === 1'b1 && blk_valid === 1'b0 && blk_last === 1'b0, "R1",
              RATE_W'({in_ready, blk_valid, blk_last}), RATE_W'(3'b100));
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1 && blk_valid === 1'b0, "R1",
              RATE_W'({in_ready, blk_valid}), RATE_W'(2'b10));
        for (int len = 1; len <= 150; len++) begin
            msg_done = 1'b0;
            fork
                drive_msg(len);
                take_blocks(len);
            join
            // R10: idle with strobe low and a stray acknowledge
            @(negedge clk);
            blk_ack = 1'b1;
            @(negedge clk);
            blk_ack = 1'b0;
            @(negedge clk);
            check(blk_valid === 1'b0 && in_ready === 1'b1, "R10",
                  RATE_W'({blk_valid, in_ready}), RATE_W'(2'b01));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule